// File: doc/BRIEF.md
# Pseudo-Virtual Page Translation Buffer with Line Prefetch

This block sits inside a memory controller and turns a pseudo-virtual page number into a physical page number. Translations are held in a small two-way set-associative table. Behind the table sit two line buffers. Each buffer holds one 128-bit page-table line, which carries the entries of two neighbouring pages. When a lookup misses the table but finds its entry in a buffer, the entry is copied into the table and answered within a single cycle.

When both the table and the buffers miss, the block asks the controller's cache for the page-table line. If the cache reports a miss, it asks for the same line again from DRAM. The returned line is stored in one buffer, the translation is answered, and the following line is then fetched into the other buffer. Sequential page walks therefore find their next entries already waiting. An entry whose valid bit is clear is answered as a fault and is never placed in the table. A single invalidate pulse empties the table and both buffers.

Top module: `pv_xlate_tlb`

## Requirements
- R1: After reset is released, `lk_ready` is 1 and both `rs_valid` and `ln_req` are 0.
- R2: A lookup that hits the table is answered on the clock edge after it is accepted: `rs_valid`=1, `rs_fault`=0 and the stored page number. No line fetch is issued.
- R3: A lookup that misses the table but whose line is held in a buffer is answered on the edge after acceptance, with no line fetch. On that same edge the entry is written into the table, if it is valid.
- R4: On a miss in both the table and the buffers, the block raises `ln_req` for one cycle with `ln_addr` = page number >> 1 and `ln_from_dram`=0. If `ln_ack` comes back with `ln_hit`=0, it re-requests the same line with `ln_from_dram`=1. An acknowledge from DRAM always carries the line.
- R5: Entry format: bits [63:0] of a line belong to the even page and bits [127:64] to the odd page. Bit 0 of an entry is its valid flag, and bits [12+PPN_W-1:12] hold the physical page number. The response appears on the edge after the acknowledge that delivered the data.
- R6: After a demand line is stored, the block fetches line+1 into the other buffer as a prefetch. `lk_ready` stays 0 from the miss until the prefetch completes. Afterwards, pages in line+1 are answered with no fetch.
- R7: An entry with bit 0 clear is answered with `rs_fault`=1 and `rs_ppn`=0, and is not written into the table.
- R8: `inv_all` empties the table and both buffers on one edge. Every later lookup then misses and fetches.
- R9: A lookup accepted in the same cycle as `inv_all` is treated as a miss.
- R10: If `inv_all` arrives while a fetch is outstanding, the response is still delivered, but the line is not kept and no prefetch follows.
- R11: The table has two ways per set, indexed by page number bits [5:0]. A fill takes an empty way if the set has one, and otherwise the least recently used way. Both hits and fills update the recency of a set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_all | input | 1 | Empty the table and both line buffers |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Pseudo-virtual page number to translate |
| lk_ready | output | 1 | Block can accept a lookup this cycle |
| rs_valid | output | 1 | Response strobe |
| rs_ppn | output | PPN_W | Translated physical page number |
| rs_fault | output | 1 | Entry was not valid |
| ln_req | output | 1 | One-cycle page-table line request |
| ln_addr | output | VPN_W-1 | Line address of the request |
| ln_from_dram | output | 1 | 0: ask the controller cache, 1: ask DRAM |
| ln_ack | input | 1 | Line request answered |
| ln_hit | input | 1 | Cache had the line (used only for cache requests) |
| ln_data | input | 128 | Page-table line, two entries |

## Verification
The invalidate pulse can land in the same cycle as other activity: as a lookup is accepted, as an entry is copied from a buffer, or while a line fetch is still in flight. The bench covers two of these cases. In the first it raises `inv_all` together with a lookup whose translation is already in the table. It expects the lookup to be answered through a fresh fetch, with the fetch count matching a demand fetch plus its prefetch. In the second it pulses `inv_all` between a demand request and its acknowledge. It expects the correct page number back, exactly one demand request with no prefetch, and a fresh fetch when the same page is looked up again.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int PTE_W       = 64;
  localparam int LINE_W      = 2 * PTE_W;
  localparam int PTE_VLD_BIT = 0;
  localparam int PTE_PPN_LSB = 12;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DREQ,
    S_DWAIT,
    S_PREQ,
    S_PWAIT
  } xlt_state_e;
endpackage

// File: rtl/xlt_sets.sv
module xlt_sets #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int SETS  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  input  logic             touch,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAYS  = 2;

  logic [SETS-1:0][WAYS-1:0] vld_q;
  logic [SETS-1:0]           lru_q;   // way to replace next
  logic [TAG_W-1:0]          tag_q [SETS][WAYS];
  logic [PPN_W-1:0]          ppn_q [SETS][WAYS];

  logic [IDX_W-1:0] lidx, widx;
  logic [TAG_W-1:0] ltag;
  logic [WAYS-1:0]  way_hit;
  logic             hit_way, vic;

  assign lidx = lk_vpn[IDX_W-1:0];
  assign ltag = lk_vpn[VPN_W-1:IDX_W];
  assign widx = wr_vpn[IDX_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_hit[w] = vld_q[lidx][w] && (tag_q[lidx][w] == ltag);
  end

  assign hit     = |way_hit;
  assign hit_way = way_hit[1];
  assign hit_ppn = ppn_q[lidx][hit_way];

  always_comb begin
    if (!vld_q[widx][0])      vic = 1'b0;
    else if (!vld_q[widx][1]) vic = 1'b1;
    else                      vic = lru_q[widx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      lru_q <= '0;
    end else if (clr) begin
      vld_q <= '0;
    end else begin
      if (touch) lru_q[lidx] <= ~hit_way;
      if (wr_en) begin
        vld_q[widx][vic] <= 1'b1;
        lru_q[widx]      <= ~vic;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) begin
      tag_q[widx][vic] <= wr_vpn[VPN_W-1:IDX_W];
      ppn_q[widx][vic] <= wr_ppn;
    end
  end
endmodule

// File: rtl/xlt_linebuf.sv
module xlt_linebuf
  import xlt_pkg::*;
#(
  parameter int VPN_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              hit,
  output logic              hit_idx,
  output logic [PTE_W-1:0]  hit_pte,
  input  logic              wr_en,
  input  logic              wr_idx,
  input  logic [VPN_W-2:0]  wr_laddr,
  input  logic [LINE_W-1:0] wr_data
);
  localparam int NBUF = 2;
  localparam int LA_W = VPN_W - 1;

  logic [NBUF-1:0]   bh;
  logic [LINE_W-1:0] dat_w [NBUF];
  logic [LINE_W-1:0] line;

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic              vld_q;
    logic [LA_W-1:0]   la_q;
    logic [LINE_W-1:0] dat_q;
    logic              sel;

    assign sel      = wr_en && (wr_idx == b[0]);
    assign bh[b]    = vld_q && (la_q == lk_vpn[VPN_W-1:1]);
    assign dat_w[b] = dat_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_q <= 1'b0;
      else if (clr) vld_q <= 1'b0;
      else if (sel) vld_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel && !clr) begin
        la_q  <= wr_laddr;
        dat_q <= wr_data;
      end
    end
  end

  assign hit     = |bh;
  assign hit_idx = bh[1];
  assign line    = dat_w[hit_idx];
  assign hit_pte = lk_vpn[0] ? line[LINE_W-1:PTE_W] : line[PTE_W-1:0];
endmodule

// File: rtl/xlt_ctrl.sv
module xlt_ctrl
  import xlt_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_ready,
  output logic              rs_valid,
  output logic [PPN_W-1:0]  rs_ppn,
  output logic              rs_fault,
  output logic              ln_req,
  output logic [VPN_W-2:0]  ln_addr,
  output logic              ln_from_dram,
  input  logic              ln_ack,
  input  logic              ln_hit,
  input  logic [LINE_W-1:0] ln_data,
  input  logic              t_hit,
  input  logic [PPN_W-1:0]  t_ppn,
  output logic              t_touch,
  output logic              t_wr,
  output logic [VPN_W-1:0]  t_wr_vpn,
  output logic [PPN_W-1:0]  t_wr_ppn,
  input  logic              b_hit,
  input  logic              b_idx,
  input  logic [PTE_W-1:0]  b_pte,
  output logic              b_wr,
  output logic              b_wr_idx,
  output logic [VPN_W-2:0]  b_wr_laddr
);
  xlt_state_e state_q, state_d;
  logic [VPN_W-1:0] vpn_q;
  logic src_q, src_d, bvic_q, bvic_d, stale_q, stale_d;
  logic rs_valid_d, rs_fault_d;
  logic [PPN_W-1:0] rs_ppn_d;

  logic acc, th, bh, keep;
  logic [VPN_W-2:0] line_q, nxt_line;
  logic [PTE_W-1:0] fpte;
  logic [PPN_W-1:0] fppn, bppn;
  logic unused_pte_bits;

  assign lk_ready     = (state_q == S_IDLE);
  assign acc          = lk_valid && lk_ready;
  assign th           = t_hit && !inv;
  assign bh           = b_hit && !inv;
  assign line_q       = vpn_q[VPN_W-1:1];
  assign nxt_line     = line_q + 1'b1;
  assign fpte         = vpn_q[0] ? ln_data[LINE_W-1:PTE_W] : ln_data[PTE_W-1:0];
  assign fppn         = fpte[PTE_PPN_LSB +: PPN_W];
  assign bppn         = b_pte[PTE_PPN_LSB +: PPN_W];
  assign keep         = !stale_q && !inv;
  assign ln_req       = (state_q == S_DREQ) || (state_q == S_PREQ);
  assign ln_addr      = (state_q == S_PREQ) ? nxt_line : line_q;
  assign ln_from_dram = src_q;
  assign unused_pte_bits = ^{fpte[PTE_W-1:PTE_PPN_LSB+PPN_W], fpte[PTE_PPN_LSB-1:1],
                             b_pte[PTE_W-1:PTE_PPN_LSB+PPN_W], b_pte[PTE_PPN_LSB-1:1]};

  always_comb begin
    state_d    = state_q;
    src_d      = src_q;
    bvic_d     = bvic_q;
    stale_d    = stale_q || (inv && state_q != S_IDLE);
    rs_valid_d = 1'b0;
    rs_ppn_d   = '0;
    rs_fault_d = 1'b0;
    t_touch    = 1'b0;
    t_wr       = 1'b0;
    t_wr_vpn   = lk_vpn;
    t_wr_ppn   = bppn;
    b_wr       = 1'b0;
    b_wr_idx   = bvic_q;
    b_wr_laddr = line_q;
    case (state_q)
      S_IDLE: begin
        stale_d = 1'b0;
        if (acc) begin
          if (th) begin
            rs_valid_d = 1'b1;
            rs_ppn_d   = t_ppn;
            t_touch    = 1'b1;
          end else if (bh) begin
            rs_valid_d = 1'b1;
            bvic_d     = ~b_idx;
            if (b_pte[PTE_VLD_BIT]) begin
              rs_ppn_d = bppn;
              t_wr     = 1'b1;
            end else begin
              rs_fault_d = 1'b1;
            end
          end else begin
            src_d   = 1'b0;
            state_d = S_DREQ;
          end
        end
      end
      S_DREQ: state_d = S_DWAIT;
      S_DWAIT: begin
        if (ln_ack) begin
          if (!ln_hit && !src_q) begin
            src_d   = 1'b1;
            state_d = S_DREQ;
          end else begin
            src_d      = 1'b0;
            rs_valid_d = 1'b1;
            if (fpte[PTE_VLD_BIT]) rs_ppn_d   = fppn;
            else                   rs_fault_d = 1'b1;
            b_wr     = keep;
            t_wr     = keep && fpte[PTE_VLD_BIT];
            t_wr_vpn = vpn_q;
            t_wr_ppn = fppn;
            state_d  = keep ? S_PREQ : S_IDLE;
          end
        end
      end
      S_PREQ: state_d = S_PWAIT;
      S_PWAIT: begin
        if (ln_ack) begin
          if (!ln_hit && !src_q) begin
            src_d   = 1'b1;
            state_d = S_PREQ;
          end else begin
            src_d      = 1'b0;
            b_wr       = keep;
            b_wr_idx   = ~bvic_q;
            b_wr_laddr = nxt_line;
            state_d    = S_IDLE;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      src_q    <= 1'b0;
      bvic_q   <= 1'b0;
      stale_q  <= 1'b0;
      rs_valid <= 1'b0;
      rs_ppn   <= '0;
      rs_fault <= 1'b0;
    end else begin
      state_q  <= state_d;
      src_q    <= src_d;
      bvic_q   <= bvic_d;
      stale_q  <= stale_d;
      rs_valid <= rs_valid_d;
      rs_ppn   <= rs_ppn_d;
      rs_fault <= rs_fault_d;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) vpn_q <= lk_vpn;
  end
endmodule

// File: rtl/pv_xlate_tlb.sv
module pv_xlate_tlb
  import xlt_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int SETS  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_ready,
  output logic              rs_valid,
  output logic [PPN_W-1:0]  rs_ppn,
  output logic              rs_fault,
  output logic              ln_req,
  output logic [VPN_W-2:0]  ln_addr,
  output logic              ln_from_dram,
  input  logic              ln_ack,
  input  logic              ln_hit,
  input  logic [LINE_W-1:0] ln_data
);
  logic [1:0] rsync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  logic             tlb_hit, tlb_touch, tlb_wr;
  logic [PPN_W-1:0] tlb_ppn, tlb_wr_ppn;
  logic [VPN_W-1:0] tlb_wr_vpn;
  logic             buf_hit, buf_idx, buf_wr, buf_wr_idx;
  logic [PTE_W-1:0] buf_pte;
  logic [VPN_W-2:0] buf_wr_laddr;

  xlt_sets #(.VPN_W(VPN_W), .PPN_W(PPN_W), .SETS(SETS)) u_sets (
    .clk(clk), .rst_n(rst_sn), .clr(inv_all), .lk_vpn(lk_vpn),
    .hit(tlb_hit), .hit_ppn(tlb_ppn), .touch(tlb_touch),
    .wr_en(tlb_wr), .wr_vpn(tlb_wr_vpn), .wr_ppn(tlb_wr_ppn)
  );

  xlt_linebuf #(.VPN_W(VPN_W)) u_lbuf (
    .clk(clk), .rst_n(rst_sn), .clr(inv_all), .lk_vpn(lk_vpn),
    .hit(buf_hit), .hit_idx(buf_idx), .hit_pte(buf_pte),
    .wr_en(buf_wr), .wr_idx(buf_wr_idx), .wr_laddr(buf_wr_laddr), .wr_data(ln_data)
  );

  xlt_ctrl #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sn), .inv(inv_all),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_ready(lk_ready),
    .rs_valid(rs_valid), .rs_ppn(rs_ppn), .rs_fault(rs_fault),
    .ln_req(ln_req), .ln_addr(ln_addr), .ln_from_dram(ln_from_dram),
    .ln_ack(ln_ack), .ln_hit(ln_hit), .ln_data(ln_data),
    .t_hit(tlb_hit), .t_ppn(tlb_ppn), .t_touch(tlb_touch), .t_wr(tlb_wr),
    .t_wr_vpn(tlb_wr_vpn), .t_wr_ppn(tlb_wr_ppn),
    .b_hit(buf_hit), .b_idx(buf_idx), .b_pte(buf_pte),
    .b_wr(buf_wr), .b_wr_idx(buf_wr_idx), .b_wr_laddr(buf_wr_laddr)
  );
endmodule

// File: rtl/xlt_chk.sv
module xlt_chk (
  input logic clk,
  input logic rst_n,
  input logic inv_all,
  input logic lk_valid,
  input logic lk_ready,
  input logic t_hit,
  input logic b_hit,
  input logic rs_valid,
  input logic rs_fault,
  input logic ln_req,
  input logic ln_ack,
  input logic ln_hit,
  input logic ln_from_dram
);
  p_hit_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && t_hit && !inv_all |=> rs_valid && !rs_fault);

  p_buf_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && !t_hit && b_hit && !inv_all |=> rs_valid && !ln_req);

  p_dram_after_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ln_ack && !ln_hit && !ln_from_dram |=> ln_req && ln_from_dram);

  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ln_req |=> !ln_req);

  p_busy_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ln_req |-> !lk_ready);

  p_inv_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !t_hit && !b_hit);

  p_inv_lookup_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && inv_all |=> !rs_valid && ln_req);
endmodule

bind pv_xlate_tlb xlt_chk u_chk (
  .clk(clk), .rst_n(rst_sn), .inv_all(inv_all), .lk_valid(lk_valid),
  .lk_ready(lk_ready), .t_hit(tlb_hit), .b_hit(buf_hit), .rs_valid(rs_valid),
  .rs_fault(rs_fault), .ln_req(ln_req), .ln_ack(ln_ack), .ln_hit(ln_hit),
  .ln_from_dram(ln_from_dram)
);

// File: tb/test_pv_xlate_tlb.sv
module test_pv_xlate_tlb;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;

  logic clk = 1'b0;
  logic rst_n, inv_all, lk_valid, ln_ack, ln_hit;
  logic [VPN_W-1:0] lk_vpn;
  logic [127:0] ln_data;
  logic lk_ready, rs_valid, rs_fault, ln_req, ln_from_dram;
  logic [PPN_W-1:0] rs_ppn;
  logic [VPN_W-2:0] ln_addr;

  always #10 clk = ~clk;  // 50 MHz

  pv_xlate_tlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .SETS(64)) i_pv_xlate_tlb (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_ready(lk_ready), .rs_valid(rs_valid), .rs_ppn(rs_ppn), .rs_fault(rs_fault),
    .ln_req(ln_req), .ln_addr(ln_addr), .ln_from_dram(ln_from_dram),
    .ln_ack(ln_ack), .ln_hit(ln_hit), .ln_data(ln_data)
  );

  int n_checks = 0, n_fail = 0, fetch_cnt = 0, fetch_base = 0;
  bit done = 0;
  logic [PPN_W-1:0] q_ppn[$];
  logic             q_flt[$];
  string            q_tag[$];

  // page-table model
  function automatic logic [PPN_W-1:0] ppn_of(input logic [VPN_W-1:0] v);
    return PPN_W'(v * 7 + 20'h01234);
  endfunction
  function automatic logic ok_of(input logic [VPN_W-1:0] v);
    return v[3:0] != 4'hD;
  endfunction
  function automatic logic [63:0] pte_of(input logic [VPN_W-1:0] v);
    return {24'hC3A5E1, 8'h00, ppn_of(v), 11'h5A5, ok_of(v)};
  endfunction
  function automatic int reqs(input logic [VPN_W-2:0] l);
    return l[1] ? 2 : 1;  // cache misses lines with bit 1 set
  endfunction
  function automatic int miss_cost(input logic [VPN_W-1:0] v);
    return reqs(v[VPN_W-1:1]) + reqs(v[VPN_W-1:1] + 1'b1);
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  // responder: controller cache and DRAM
  int pend = 0;
  logic [VPN_W-2:0] p_addr, miss_addr;
  logic p_dram, miss_pend = 0;
  initial begin
    ln_ack = 0; ln_hit = 0; ln_data = '0;
    forever begin
      @(negedge clk);
      if (ln_ack) ln_ack = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          ln_ack  = 1;
          ln_hit  = p_dram | !p_addr[1];
          ln_data = ln_hit ? {pte_of({p_addr, 1'b1}), pte_of({p_addr, 1'b0})} : '0;
          if (!ln_hit) begin miss_pend = 1; miss_addr = p_addr; end
        end
      end
      if (ln_req) begin
        fetch_cnt++;
        p_addr = ln_addr; p_dram = ln_from_dram; pend = 2;
        if (ln_from_dram) begin
          check(miss_pend && miss_addr == ln_addr, "R4 DRAM request only after cache miss on same line",
                int'(ln_addr), int'(miss_addr));
          miss_pend = 0;
        end
      end
    end
  end

  // monitor: scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rs_valid) begin
        if (q_tag.size() == 0) check(0, "unexpected response", int'(rs_ppn), 0);
        else begin
          automatic logic [PPN_W-1:0] ep = q_ppn.pop_front();
          automatic logic ef = q_flt.pop_front();
          automatic string t = q_tag.pop_front();
          check(rs_ppn == ep && rs_fault == ef, {t, " response"},
                int'({rs_fault, rs_ppn}), int'({ef, ep}));
        end
      end
    end
  end

  task automatic do_lookup(input logic [VPN_W-1:0] v, input bit with_inv, input string tag);
    @(negedge clk);
    while (!lk_ready) @(negedge clk);
    lk_valid = 1; lk_vpn = v; inv_all = with_inv;
    q_ppn.push_back(ok_of(v) ? ppn_of(v) : '0);
    q_flt.push_back(!ok_of(v));
    q_tag.push_back(tag);
    @(negedge clk);
    lk_valid = 0; inv_all = 0;
  endtask

  task automatic pulse_inv();
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (!(lk_ready && q_tag.size() == 0)) @(negedge clk);
  endtask

  task automatic check_fetch(input int exp, input string tag);
    settle();
    check(fetch_cnt - fetch_base == exp, {tag, " line requests"}, fetch_cnt - fetch_base, exp);
    fetch_base = fetch_cnt;
  endtask

  localparam logic [VPN_W-1:0] VA = 20'h00040, VB = 20'h00080, VC = 20'h000C0;

  initial begin
    rst_n = 0; inv_all = 0; lk_valid = 0; lk_vpn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(lk_ready == 1, "R1 lk_ready after reset", lk_ready, 1);
    check(rs_valid == 0, "R1 rs_valid after reset", rs_valid, 0);
    check(ln_req == 0, "R1 ln_req after reset", ln_req, 0);

    do_lookup(20'h00100, 0, "R4 R5 demand miss even page");
    check_fetch(miss_cost(20'h00100), "R4 R6 demand plus prefetch");
    do_lookup(20'h00101, 0, "R3 R5 odd page from buffer");
    check_fetch(0, "R3 buffer hit");
    do_lookup(20'h00100, 0, "R2 table hit");
    check_fetch(0, "R2 table hit");
    do_lookup(20'h00102, 0, "R6 prefetched line");
    check_fetch(0, "R6 prefetched line");
    do_lookup(20'h00204, 0, "R4 cache miss then DRAM");
    check_fetch(miss_cost(20'h00204), "R4 cache miss then DRAM");
    do_lookup(20'h0030D, 0, "R7 invalid entry fault");
    check_fetch(miss_cost(20'h0030D), "R7 fault fetch");
    do_lookup(20'h0030D, 0, "R7 repeated fault");
    check_fetch(0, "R7 repeated fault");

    pulse_inv();
    do_lookup(20'h00100, 0, "R8 lookup after invalidate");
    check_fetch(miss_cost(20'h00100), "R8 refetch after invalidate");

    pulse_inv();
    do_lookup(VA, 0, "R11 fill A");
    do_lookup(VB, 0, "R11 fill B");
    check_fetch(miss_cost(VA) + miss_cost(VB), "R11 fills A and B");
    do_lookup(VA, 0, "R11 touch A");
    check_fetch(0, "R11 touch A");
    do_lookup(VC, 0, "R11 fill C evicts B");
    check_fetch(miss_cost(VC), "R11 fill C");
    do_lookup(VA, 0, "R11 A kept");
    check_fetch(0, "R11 A kept");
    do_lookup(VB, 0, "R11 B evicted");
    check_fetch(miss_cost(VB), "R11 B evicted");

    do_lookup(VA, 1, "R9 lookup with invalidate");
    check_fetch(miss_cost(VA), "R9 lookup with invalidate misses");

    do_lookup(20'h00500, 0, "R10 invalidate during fetch");
    pulse_inv();
    check_fetch(reqs(20'h00500 >> 1), "R10 no prefetch after invalidate");
    do_lookup(20'h00500, 0, "R10 line not retained");
    check_fetch(miss_cost(20'h00500), "R10 line not retained");
    do_lookup(20'h00501, 0, "R3 neighbour after refill");
    check_fetch(0, "R3 neighbour after refill");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule